// File: doc/BRIEF.md
# Background Comparator Threshold Adaptation

This block holds one signed trim word per comparator of a parallel quantizer and keeps refining those words while conversion carries on. An external error detector delivers, for one comparator index at a time, a signed error sample together with a strobe. The block keeps a per-index exponential average of the errors already seen for that index. It moves the addressed trim word by the deviation of the new sample from that average, scaled down by a programmable power of two. It then folds the sample into the average. Only the addressed entry changes, so conversion on every other comparator is never disturbed.

Each applied update is echoed on a registered result port one cycle after its strobe. A combinational read port returns any trim word of the table. A write port preloads starting trims, for example after a foreground measurement. A freeze input holds every trim and average while it is asserted. Trim words saturate at their signed limits instead of wrapping, so a long run of one-sided errors cannot flip a threshold to the far end of the range.

Top module: `cmp_thresh_adapt`

## Requirements
- R1: A synchronous active-high reset clears every trim word and every running average to zero and drives `upd_valid` low.
- R2: For an applied strobe at index k with error e and gain shift g, let A be the stored average of k in units of 1/16 LSB and D = 16·e − A. The trim of k becomes its old value plus floor(D / 2^(g+4)).
- R3: On the same applied strobe the average of k becomes A + floor(D / 16), so the deviation always uses the average of earlier samples only.
- R4: A trim result above +511 is stored as +511, and one below −512 is stored as −512 (10-bit two's complement).
- R5: The cycle after an applied strobe, `upd_valid` is high for one cycle, `upd_idx` carries k and `upd_trim` carries the new trim. The read port returns the new trim for k in that same cycle.
- R6: While `freeze` is high, strobes change no trim and no average and produce no `upd_valid`.
- R7: `wr_en` replaces the trim of `wr_idx` at the next edge and leaves its average unchanged. When a write and a strobe target the same index in one cycle, the write takes effect and the strobe is dropped.
- R8: A strobe or read with an index of 63 or above touches nothing and reads as zero.
- R9: An applied strobe changes only the entry it addresses. Writes and strobes to different indices in one cycle both take effect.
- R10: The gain shift takes every value from 0 to 15, and shifts larger than the deviation width give −1 or 0 (floor).
- R11: Strobes may arrive every cycle, including repeatedly to one index, and each one uses the state left by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Hold all trims and averages |
| gain_shift | input | 4 | Adaptation gain as a right-shift amount |
| err_valid | input | 1 | Error sample strobe |
| err_idx | input | 6 | Comparator index of the sample |
| err_val | input | 8 | Signed error sample |
| wr_en | input | 1 | Preload write enable |
| wr_idx | input | 6 | Preload index |
| wr_trim | input | 10 | Signed preload trim value |
| rd_idx | input | 6 | Read port index |
| rd_trim | output | 10 | Signed trim at `rd_idx` |
| upd_valid | output | 1 | An update was applied last cycle |
| upd_idx | output | 6 | Index of that update |
| upd_trim | output | 10 | Signed new trim of that update |

## Verification
The bench drives trims into both saturation limits. A design that wraps would echo a value of the opposite sign. Deviations are driven negative at large gain shifts to expose truncation toward zero in place of floor. Repeated strobes to one index in consecutive cycles would show a stale average or trim if the update used old state. A write and a strobe that collide on one index would show the adapted value instead of the preload if the priority were reversed. Strobes under freeze and strobes to index 63 are followed by a full table compare, so a leak into the stored state cannot hide behind a silent result port.

// File: rtl/cta_pkg.sv
`timescale 1ns/1ps
package cta_pkg;

    localparam int TRIM_W   = 10;
    localparam int ERR_W    = 8;
    localparam int AVG_FRAC = 4;
    localparam int GAIN_W   = 4;
    localparam int AVG_W    = ERR_W + AVG_FRAC;
    localparam int DIFF_W   = AVG_W + 1;
    localparam int SUM_W    = ((DIFF_W > TRIM_W) ? DIFF_W : TRIM_W) + 1;

    typedef logic signed [TRIM_W-1:0] trim_t;
    typedef logic signed [ERR_W-1:0]  err_t;
    typedef logic signed [AVG_W-1:0]  avg_t;
    typedef logic signed [DIFF_W-1:0] diff_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    typedef struct packed {
        trim_t trim;
        avg_t  avg;
    } entry_t;

    localparam trim_t TRIM_MAX = trim_t'({1'b0, {(TRIM_W-1){1'b1}}});
    localparam trim_t TRIM_MIN = trim_t'({1'b1, {(TRIM_W-1){1'b0}}});

    // Deviation of a sample from the running mean, in 1/2^AVG_FRAC LSB units
    function automatic diff_t deviation(input err_t e, input avg_t a);
        return (diff_t'(e) <<< AVG_FRAC) - diff_t'(a);
    endfunction

    // Exponential-average increment: floor of deviation / 2^AVG_FRAC
    function automatic avg_t avg_step(input diff_t d);
        diff_t s;
        s = d >>> AVG_FRAC;
        return avg_t'(s);
    endfunction

    // Clamp a wide sum into the trim range
    function automatic trim_t sat_trim(input sum_t s);
        if (s > sum_t'(TRIM_MAX))
            return TRIM_MAX;
        else if (s < sum_t'(TRIM_MIN))
            return TRIM_MIN;
        else
            return trim_t'(s);
    endfunction

endpackage

// File: rtl/cta_update_path.sv
`timescale 1ns/1ps
module cta_update_path
    import cta_pkg::*;
(
    input  entry_t             cur,
    input  err_t               err,
    input  logic [GAIN_W-1:0]  gain,
    output entry_t             nxt
);

    diff_t dev;
    diff_t step;
    sum_t  acc;

    always_comb begin
        dev      = deviation(err, cur.avg);
        // Gain and fixed-point scaling merged into one arithmetic shift (floor)
        step     = dev >>> (int'(gain) + AVG_FRAC);
        acc      = sum_t'(cur.trim) + sum_t'(step);
        nxt.trim = sat_trim(acc);
        nxt.avg  = cur.avg + avg_step(dev);
    end

endmodule

// File: rtl/cta_select.sv
`timescale 1ns/1ps
module cta_select
    import cta_pkg::*;
#(
    parameter int N  = 63,
    parameter int IW = 6
)(
    input  entry_t          table_i [N],
    input  logic [IW-1:0]   idx,
    output entry_t          pick,
    output logic            hit
);

    always_comb begin
        pick = '0;
        hit  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (idx == IW'(i)) begin
                pick = table_i[i];
                hit  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cta_entry.sv
`timescale 1ns/1ps
module cta_entry
    import cta_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_en,
    input  logic   wr_en,
    input  trim_t  wr_trim,
    input  entry_t nxt,
    output entry_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q.trim <= wr_trim;
        end else if (upd_en) begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/cmp_thresh_adapt.sv
`timescale 1ns/1ps
module cmp_thresh_adapt
    import cta_pkg::*;
#(
    parameter int NUM_CMP = 63,
    localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     freeze,
    input  logic [GAIN_W-1:0]        gain_shift,
    input  logic                     err_valid,
    input  logic [IDX_W-1:0]         err_idx,
    input  logic signed [ERR_W-1:0]  err_val,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [TRIM_W-1:0] wr_trim,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [TRIM_W-1:0] rd_trim,
    output logic                     upd_valid,
    output logic [IDX_W-1:0]         upd_idx,
    output logic signed [TRIM_W-1:0] upd_trim
);

    entry_t tbl [NUM_CMP];
    entry_t cur;
    entry_t nxt;
    entry_t rd_pick;
    logic   cur_hit;
    logic   rd_hit;
    logic   clash;
    logic   apply;

    cta_select #(.N(NUM_CMP), .IW(IDX_W)) u_fetch (
        .table_i (tbl),
        .idx     (err_idx),
        .pick    (cur),
        .hit     (cur_hit)
    );

    cta_select #(.N(NUM_CMP), .IW(IDX_W)) u_read (
        .table_i (tbl),
        .idx     (rd_idx),
        .pick    (rd_pick),
        .hit     (rd_hit)
    );

    cta_update_path u_path (
        .cur  (cur),
        .err  (err_val),
        .gain (gain_shift),
        .nxt  (nxt)
    );

    // A preload to the strobed index overrides the adaptation step
    assign clash = wr_en && (wr_idx == err_idx);
    assign apply = err_valid && !freeze && cur_hit && !clash;

    generate
        for (genvar i = 0; i < NUM_CMP; i++) begin : g_ent
            logic sel_upd;
            logic sel_wr;
            assign sel_upd = apply && (err_idx == IDX_W'(i));
            assign sel_wr  = wr_en && (wr_idx == IDX_W'(i));
            cta_entry u_ent (
                .clk     (clk),
                .rst     (rst),
                .upd_en  (sel_upd),
                .wr_en   (sel_wr),
                .wr_trim (wr_trim),
                .nxt     (nxt),
                .q       (tbl[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_valid <= 1'b0;
            upd_idx   <= '0;
            upd_trim  <= '0;
        end else begin
            upd_valid <= apply;
            if (apply) begin
                upd_idx  <= err_idx;
                upd_trim <= nxt.trim;
            end
        end
    end

    assign rd_trim = rd_hit ? rd_pick.trim : '0;

endmodule

// File: rtl/cta_checker.sv
`timescale 1ns/1ps
module cta_checker
    import cta_pkg::*;
#(
    parameter int NUM_CMP = 63,
    localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
)(
    input logic                     clk,
    input logic                     rst,
    input logic                     freeze,
    input logic                     err_valid,
    input logic [IDX_W-1:0]         err_idx,
    input logic                     wr_en,
    input logic [IDX_W-1:0]         wr_idx,
    input logic signed [TRIM_W-1:0] wr_trim,
    input logic [IDX_W-1:0]         rd_idx,
    input logic signed [TRIM_W-1:0] rd_trim,
    input logic                     upd_valid,
    input logic [IDX_W-1:0]         upd_idx
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> !upd_valid);

    assert_freeze_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        freeze |=> !upd_valid);

    assert_range_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (err_valid && (int'(err_idx) >= NUM_CMP)) |=> !upd_valid);

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && err_valid && (wr_idx == err_idx)) |=> !upd_valid);

    assert_idx_echo_R5: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> ($past(err_valid) && (upd_idx == $past(err_idx))));

    assert_preload_visible_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && (int'($past(wr_idx)) < NUM_CMP)
         && (rd_idx == $past(wr_idx))) |-> (rd_trim == $past(wr_trim)));

endmodule

bind cmp_thresh_adapt cta_checker #(.NUM_CMP(NUM_CMP)) i_cta_checker (
    .clk       (clk),
    .rst       (rst),
    .freeze    (freeze),
    .err_valid (err_valid),
    .err_idx   (err_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_trim   (wr_trim),
    .rd_idx    (rd_idx),
    .rd_trim   (rd_trim),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx)
);

// File: tb/test_cmp_thresh_adapt.sv
`timescale 1ns/1ps
module test_cmp_thresh_adapt;

    localparam int N = 63;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              freeze = 1'b0;
    logic [3:0]        gain_shift = '0;
    logic              err_valid = 1'b0;
    logic [5:0]        err_idx = '0;
    logic signed [7:0] err_val = '0;
    logic              wr_en = 1'b0;
    logic [5:0]        wr_idx = '0;
    logic signed [9:0] wr_trim = '0;
    logic [5:0]        rd_idx = '0;
    logic signed [9:0] rd_trim;
    logic              upd_valid;
    logic [5:0]        upd_idx;
    logic signed [9:0] upd_trim;

    cmp_thresh_adapt i_cmp_thresh_adapt (
        .clk(clk), .rst(rst), .freeze(freeze), .gain_shift(gain_shift),
        .err_valid(err_valid), .err_idx(err_idx), .err_val(err_val),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_trim(wr_trim),
        .rd_idx(rd_idx), .rd_trim(rd_trim),
        .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_trim(upd_trim)
    );

    always #2.5 clk = ~clk;

    typedef struct { int idx; int trim; string tag; } exp_t;
    exp_t exp_q[$];

    int m_trim [N];
    int m_avg  [N];
    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Scoreboard monitor: one expected item per applied update
    always @(negedge clk) begin
        if (!rst && upd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6/R8 unexpected upd_valid", int'(upd_idx), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(upd_idx) == e.idx, {e.tag, " idx"}, int'(upd_idx), e.idx);
                check(int'(upd_trim) == e.trim, {e.tag, " trim"}, int'(upd_trim), e.trim);
            end
        end
    end

    // Driver: called at a falling edge, leaves at the next falling edge
    task automatic send(input int idx, input int e, input string tag);
        err_valid = 1'b1;
        err_idx   = 6'(idx);
        err_val   = 8'(e);
        if (!freeze && idx < N && !(wr_en && int'(wr_idx) == idx)) begin
            int d, step, t;
            exp_t x;
            d    = e * 16 - m_avg[idx];
            step = d >>> (int'(gain_shift) + 4);
            t    = m_trim[idx] + step;
            if (t > 511)  t = 511;
            if (t < -512) t = -512;
            m_trim[idx] = t;
            m_avg[idx]  = m_avg[idx] + (d >>> 4);
            x.idx = idx; x.trim = t; x.tag = tag;
            exp_q.push_back(x);
        end
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    task automatic preload(input int idx, input int v);
        wr_en   = 1'b1;
        wr_idx  = 6'(idx);
        wr_trim = 10'(v);
        if (idx < N) m_trim[idx] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input int idx, input int expv, input string tag);
        rd_idx = 6'(idx);
        #1;
        check(int'(rd_trim) == expv, tag, int'(rd_trim), expv);
    endtask

    task automatic table_check(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < N; i++) begin
            rd_idx = 6'(i);
            #0.1;
            if (int'(rd_trim) != m_trim[i]) begin
                if (bad == 0)
                    $display("FAIL %s entry %0d actual=%0d expected=%0d", tag, i, int'(rd_trim), m_trim[i]);
                bad++;
            end
        end
        tests++;
        if (bad != 0) fails++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned s;
        for (int i = 0; i < N; i++) begin m_trim[i] = 0; m_avg[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(upd_valid == 1'b0, "R1 upd_valid after reset", int'(upd_valid), 0);
        table_check("R1 table cleared");

        // R7: preload and read back
        preload(5, 100);
        preload(62, -200);
        read_check(5, 100, "R7 preload idx5");
        read_check(62, -200, "R7 preload idx62");

        // R2/R3/R5: first update, gain 0: D=320, step 20, trim 120
        gain_shift = 4'd0;
        send(5, 20, "R2 basic gain0");
        read_check(5, 120, "R5 read next cycle");
        // second: A=20, D=320-20=300, step floor(300/16)=18 -> 138
        send(5, 20, "R3 average used");
        read_check(5, 138, "R3 trim after avg");

        // R10: gain shifts with negative deviations (floor)
        gain_shift = 4'd3;
        for (int k = 0; k < 6; k++) send(7, -37, "R10 gain3 negative");
        gain_shift = 4'd15;
        send(8, 1, "R10 gain15 positive");
        send(9, -1, "R10 gain15 floor negative");
        read_check(9, -1, "R10 gain15 floor value");

        // R4: saturation both ends
        gain_shift = 4'd0;
        preload(10, 500);
        send(10, 127, "R4 high clamp");
        read_check(10, 511, "R4 high clamp stored");
        preload(11, -500);
        send(11, -128, "R4 low clamp");
        read_check(11, -512, "R4 low clamp stored");

        // R6: freeze holds trims and averages
        freeze = 1'b1;
        send(5, 90, "R6 frozen");
        send(7, -90, "R6 frozen");
        freeze = 1'b0;
        table_check("R6 table unchanged under freeze");
        send(5, 20, "R6 average untouched after freeze");

        // R8: out-of-range index
        send(63, 55, "R8 idx63");
        read_check(63, 0, "R8 read idx63");
        table_check("R8 table unchanged");

        // R7/R9: collision on one index, and parallel different indices
        wr_en = 1'b1; wr_idx = 6'd20; wr_trim = 10'sd77; m_trim[20] = 77;
        send(20, 100, "R7 collision");
        wr_en = 1'b0;
        read_check(20, 77, "R7 write wins");
        send(20, 0, "R7 average kept at zero");
        wr_en = 1'b1; wr_idx = 6'd21; wr_trim = -10'sd33; m_trim[21] = -33;
        send(22, 40, "R9 parallel strobe");
        wr_en = 1'b0;
        read_check(21, -33, "R9 parallel write");

        // R11: back-to-back strobes to one index
        gain_shift = 4'd1;
        send(30, 60, "R11 b2b");
        send(30, 60, "R11 b2b");
        send(30, -60, "R11 b2b");
        send(31, 5, "R11 b2b other");

        // R9/R2 sweep with varied indices, errors, gains
        s = 32'h1234_5678;
        for (int k = 0; k < 400; k++) begin
            s = s * 32'd1103515245 + 32'd12345;
            gain_shift = 4'(s[27:24] % 8);
            send(int'(s[21:16]), int'($signed(s[15:8])), "R9 sweep");
        end
        table_check("R9 table after sweep");

        @(negedge clk);
        check(exp_q.size() == 0, "R5 all updates observed", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule